// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a segment:offset logical address into a 32-bit linear address. It keeps a small set of segment registers: code, data and stack in the default build. Each register has a hidden cache that holds the decoded descriptor for the selector last loaded into it. Loading a selector starts one 8-byte descriptor read from either the global or the local descriptor table, using a request/valid handshake to memory. Once the read returns, the decoded base, limit and attributes go into that register's cache. Later translations read only the cache and never touch the tables.

A translation request names a segment register and a 32-bit offset. One cycle later the block returns the sum of the cached base and the offset. If the offset lies beyond the effective limit, it returns a protection fault instead. The limit can be scaled to 4 KB pages by the descriptor's granularity flag. The descriptor attributes and the requested privilege level of the selector are passed out with each result, for recording only. A translation that names a register whose descriptor is still being fetched is held off until the fetch completes. Only one descriptor fetch is in flight at a time.

Top module: `seg_xlate`

## Requirements
- R1: After reset every segment register holds a null descriptor: a translation through any register faults. `load_ready` is 1, and `mem_req` and `xl_ack` are 0.
- R2: A selector is 16 bits. Bits 15:3 are the descriptor index, bit 2 selects the table (0 selects `gdt_base`, 1 selects `ldt_base`) and bits 1:0 are the requested privilege level. A non-null load drives `mem_addr` = table base + index*8, starting the cycle after the load is accepted. `mem_req` stays high, with `mem_addr` unchanged, until the cycle in which `mem_valid` is 1.
- R3: A selector whose bits 15:2 are all zero is null. Loading it issues no memory request, and a later translation through that register faults.
- R4: A translation accepted at a clock edge raises `xl_ack` for one cycle after that edge. When there is no fault, `xl_lin` = cached base + `xl_off`, taken modulo 2^32.
- R5: When the granularity flag is 0, the effective limit is the 20-bit limit in bytes. An offset equal to the limit translates. An offset one above the limit sets `xl_fault`, and `xl_lin` reads 0.
- R6: When the granularity flag is 1, the effective limit is the 20-bit limit shifted left by 12, with the low 12 bits set to one. The offset is compared against that value.
- R7: While a fetch is outstanding for a register, `xl_stall` is 1 for a translation to that register, and no `xl_ack` follows. Translations to the other registers proceed as normal.
- R8: After a load completes, translations use only the cache. Later changes to `gdt_base`, `ldt_base` or `mem_data` do not alter their results, and translations raise no `mem_req`.
- R9: Descriptor fields are decoded as follows. Base = {bits 63:56, bits 39:16}. Limit = {bits 51:48, bits 15:0}. Type = bits 43:40. The system/user flag is bit 44, the DPL is bits 46:45 and the granularity flag is bit 55. Each result reports type, flag, DPL and the selector's bits 1:0.
- R10: `load_ready` is 0 while a fetch is outstanding. A load presented then is ignored and leaves every register unchanged.
- R11: A translation that names a register number of `NUM_SEGS` or above faults. The encoding is 0 code, 1 data, 2 stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gdt_base | input | 32 | Base address of the global descriptor table |
| ldt_base | input | 32 | Base address of the local descriptor table |
| load_valid | input | 1 | Selector load request |
| load_seg | input | 2 | Segment register to load (0 code, 1 data, 2 stack) |
| load_sel | input | 16 | Selector value to load |
| load_ready | output | 1 | Load can be accepted this cycle |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_valid | input | 1 | Descriptor data valid |
| mem_data | input | 64 | Descriptor data |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 2 | Segment register to translate through |
| xl_off | input | 32 | Offset within the segment |
| xl_stall | output | 1 | Translation held off; the named register is being reloaded |
| xl_ack | output | 1 | Translation result valid |
| xl_lin | output | 32 | Linear address (0 on fault) |
| xl_fault | output | 1 | Protection fault |
| xl_type | output | 4 | Descriptor type field |
| xl_sys | output | 1 | Descriptor system/user flag |
| xl_dpl | output | 2 | Descriptor privilege level |
| xl_rpl | output | 2 | Requested privilege level from the selector |

## Verification
The in-RTL assertions check the fetch handshake on every cycle. They cover the following: the request is held with a stable address, loads are blocked while a fetch is pending, null loads raise no request, every accepted translation is acknowledged a cycle later, and a stalled translation is never acknowledged. Other behaviours can only be shown by the bench's directed scenarios with known descriptors. These are the arithmetic results (base-plus-offset sums with wraparound, byte and page limit edges), the split-field decoding, the fault on out-of-range register numbers, and the fact that cached results survive changes to the table bases and the memory data.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int SEL_W  = 16;
   localparam int IDX_W  = 13;
   localparam int DESC_W = 64;
   localparam int LIN_W  = 32;
   localparam int LIM_W  = 20;
   localparam int PAGE_SH = 12;

   typedef struct packed {
      logic [LIN_W-1:0] base;
      logic [LIM_W-1:0] limit;
      logic             gran;
      logic             sys;
      logic [3:0]       typ;
      logic [1:0]       dpl;
      logic [1:0]       rpl;
      logic             is_null;
   } seg_cache_t;

   function automatic logic sel_null(input logic [SEL_W-1:0] sel);
      return (sel[SEL_W-1:2] == '0);
   endfunction

   function automatic seg_cache_t null_entry(input logic [1:0] rpl);
      seg_cache_t e;
      e = '0;
      e.is_null = 1'b1;
      e.rpl = rpl;
      return e;
   endfunction

   // split-field descriptor layout; the bit positions are part of the contract
   function automatic seg_cache_t desc_decode(input logic [DESC_W-1:0] d,
                                              input logic [1:0] rpl);
      seg_cache_t e;
      e.base    = {d[63:56], d[39:16]};
      e.limit   = {d[51:48], d[15:0]};
      e.gran    = d[55];
      e.sys     = d[44];
      e.typ     = d[43:40];
      e.dpl     = d[46:45];
      e.rpl     = rpl;
      e.is_null = 1'b0;
      return e;
   endfunction
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIN_W-1:0]  gdt_base,
   input  logic [LIN_W-1:0]  ldt_base,
   input  logic              load_valid,
   input  logic [SEG_W-1:0]  load_seg,
   input  logic [SEL_W-1:0]  load_sel,
   output logic              load_ready,
   output logic              mem_req,
   output logic [LIN_W-1:0]  mem_addr,
   input  logic              mem_valid,
   input  logic [DESC_W-1:0] mem_data,
   output logic              wr_en,
   output logic [SEG_W-1:0]  wr_seg,
   output seg_cache_t        wr_entry,
   output logic [SEG_W-1:0]  busy_seg
);
   localparam int PAD_W = LIN_W - IDX_W - 3;

   logic             pend_q;
   logic [SEG_W-1:0] pend_seg_q;
   logic [1:0]       pend_rpl_q;
   logic [LIN_W-1:0] addr_q;
   logic             accept, is_null;
   logic [LIN_W-1:0] fetch_addr;

   assign load_ready = !pend_q;
   assign accept     = load_valid && !pend_q;
   assign is_null    = sel_null(load_sel);
   assign fetch_addr = (load_sel[2] ? ldt_base : gdt_base)
                     + {{PAD_W{1'b0}}, load_sel[SEL_W-1:3], 3'b000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_seg_q <= '0;
         pend_rpl_q <= '0;
         addr_q     <= '0;
      end else if (accept && !is_null) begin
         pend_q     <= 1'b1;
         pend_seg_q <= load_seg;
         pend_rpl_q <= load_sel[1:0];
         addr_q     <= fetch_addr;
      end else if (pend_q && mem_valid) begin
         pend_q <= 1'b0;
      end
   end

   assign mem_req  = pend_q;
   assign mem_addr = addr_q;
   assign busy_seg = pend_seg_q;

   always_comb begin
      wr_en    = (accept && is_null) || (pend_q && mem_valid);
      wr_seg   = pend_q ? pend_seg_q : load_seg;
      wr_entry = pend_q ? desc_decode(mem_data, pend_rpl_q)
                        : null_entry(load_sel[1:0]);
   end

   // R2: request held with a stable address until data returns
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   // R10: no load can be accepted while a fetch is pending
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !load_ready);
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS = 3,
   parameter int SEG_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEG_W-1:0] wr_seg,
   input  seg_cache_t       wr_entry,
   input  logic [SEG_W-1:0] rd_seg,
   output seg_cache_t       rd_entry,
   output logic             rd_inrange
);
   seg_cache_t slot [NUM_SEGS];

   for (genvar g = 0; g < NUM_SEGS; g++) begin : g_reg
      seg_cache_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= null_entry(2'b00);
         else if (wr_en && (wr_seg == SEG_W'(g)))
            q <= wr_entry;
      end
      assign slot[g] = q;
   end

   always_comb begin
      rd_entry   = null_entry(2'b00);
      rd_inrange = 1'b0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (rd_seg == SEG_W'(i)) begin
            rd_entry   = slot[i];
            rd_inrange = 1'b1;
         end
      end
   end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
   import seg_xlate_pkg::*;
#(
   parameter bit GRAN_EN = 1'b1
) (
   input  logic [LIN_W-1:0] base,
   input  logic [LIM_W-1:0] limit,
   input  logic             gran,
   input  logic [LIN_W-1:0] off,
   output logic [LIN_W-1:0] lin,
   output logic             over
);
   localparam int HI_PAD = LIN_W - LIM_W;

   logic [LIN_W-1:0] eff_limit;

   if (GRAN_EN) begin : g_paged
      assign eff_limit = gran ? {limit, {PAGE_SH{1'b1}}}
                              : {{HI_PAD{1'b0}}, limit};
   end else begin : g_bytes
      logic unused_gran;
      assign unused_gran = gran;
      assign eff_limit = {{HI_PAD{1'b0}}, limit};
   end

   assign lin  = base + off;
   assign over = off > eff_limit;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEGS = 3,
   parameter bit GRAN_EN  = 1'b1,
   localparam int SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       gdt_base,
   input  logic [31:0]       ldt_base,
   input  logic              load_valid,
   input  logic [SEG_W-1:0]  load_seg,
   input  logic [15:0]       load_sel,
   output logic              load_ready,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_valid,
   input  logic [63:0]       mem_data,
   input  logic              xl_valid,
   input  logic [SEG_W-1:0]  xl_seg,
   input  logic [31:0]       xl_off,
   output logic              xl_stall,
   output logic              xl_ack,
   output logic [31:0]       xl_lin,
   output logic              xl_fault,
   output logic [3:0]        xl_type,
   output logic              xl_sys,
   output logic [1:0]        xl_dpl,
   output logic [1:0]        xl_rpl
);
   if (NUM_SEGS < 1 || NUM_SEGS > 8) begin : g_bad_segs
      $error("seg_xlate: NUM_SEGS must be 1..8");
   end
   if (LIN_W != 32 || DESC_W != 64) begin : g_bad_widths
      $error("seg_xlate: descriptor layout needs 32-bit linear and 64-bit descriptor");
   end

   logic             wr_en;
   logic [SEG_W-1:0] wr_seg;
   seg_cache_t       wr_entry;
   logic [SEG_W-1:0] busy_seg;
   seg_cache_t       rd_entry;
   logic             rd_inrange;
   logic [31:0]      raw_lin;
   logic             over;
   logic             fire, fault_now;

   seg_desc_fetch #(.SEG_W(SEG_W)) u_fetch (
      .clk(clk), .rst_n(rst_n),
      .gdt_base(gdt_base), .ldt_base(ldt_base),
      .load_valid(load_valid), .load_seg(load_seg), .load_sel(load_sel),
      .load_ready(load_ready),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_data(mem_data),
      .wr_en(wr_en), .wr_seg(wr_seg), .wr_entry(wr_entry),
      .busy_seg(busy_seg)
   );

   seg_cache_bank #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_seg(wr_seg), .wr_entry(wr_entry),
      .rd_seg(xl_seg), .rd_entry(rd_entry), .rd_inrange(rd_inrange)
   );

   seg_limit_check #(.GRAN_EN(GRAN_EN)) u_limit (
      .base(rd_entry.base), .limit(rd_entry.limit), .gran(rd_entry.gran),
      .off(xl_off), .lin(raw_lin), .over(over)
   );

   assign xl_stall  = xl_valid && mem_req && (xl_seg == busy_seg);
   assign fire      = xl_valid && !xl_stall;
   assign fault_now = !rd_inrange || rd_entry.is_null || over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_ack   <= 1'b0;
         xl_lin   <= '0;
         xl_fault <= 1'b0;
         xl_type  <= '0;
         xl_sys   <= 1'b0;
         xl_dpl   <= '0;
         xl_rpl   <= '0;
      end else begin
         xl_ack <= fire;
         if (fire) begin
            xl_fault <= fault_now;
            xl_lin   <= fault_now ? '0 : raw_lin;
            xl_type  <= rd_entry.typ;
            xl_sys   <= rd_entry.sys;
            xl_dpl   <= rd_entry.dpl;
            xl_rpl   <= rd_entry.rpl;
         end
      end
   end

   // R4: an accepted translation is acknowledged on the next cycle
   a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_stall) |=> xl_ack);

   // R7: a stalled translation never produces an acknowledge
   a_r7_stall_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && xl_stall) |=> !xl_ack);

   // R3: a null selector load starts no memory request
   a_r3_null_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && load_ready && (load_sel[15:2] == '0)) |=> !mem_req);
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] gdt_base = 32'h0001_0000;
   logic [31:0] ldt_base = 32'h0080_0000;
   logic        load_valid = 1'b0;
   logic [1:0]  load_seg = '0;
   logic [15:0] load_sel = '0;
   logic        load_ready, mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [63:0] mem_data = '0;
   logic        xl_valid = 1'b0;
   logic [1:0]  xl_seg = '0;
   logic [31:0] xl_off = '0;
   logic        xl_stall, xl_ack, xl_fault, xl_sys;
   logic [31:0] xl_lin;
   logic [3:0]  xl_type;
   logic [1:0]  xl_dpl, xl_rpl;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_xlate u_seg_xlate (
      .clk(clk), .rst_n(rst_n), .gdt_base(gdt_base), .ldt_base(ldt_base),
      .load_valid(load_valid), .load_seg(load_seg), .load_sel(load_sel),
      .load_ready(load_ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_data(mem_data),
      .xl_valid(xl_valid), .xl_seg(xl_seg), .xl_off(xl_off),
      .xl_stall(xl_stall), .xl_ack(xl_ack), .xl_lin(xl_lin), .xl_fault(xl_fault),
      .xl_type(xl_type), .xl_sys(xl_sys), .xl_dpl(xl_dpl), .xl_rpl(xl_rpl)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_desc(input logic [31:0] base,
      input logic [19:0] lim, input bit g, input logic [3:0] typ,
      input bit s, input logic [1:0] dpl);
      logic [63:0] d;
      d = '0;
      d[15:0]  = lim[15:0];
      d[51:48] = lim[19:16];
      d[39:16] = base[23:0];
      d[63:56] = base[31:24];
      d[43:40] = typ;
      d[44]    = s;
      d[46:45] = dpl;
      d[47]    = 1'b1;
      d[55]    = g;
      return d;
   endfunction

   // load a selector; if a fetch is expected, answer it after 'delay' cycles
   task automatic do_load(input logic [1:0] seg, input logic [15:0] sel,
      input bit exp_req, input logic [31:0] exp_addr,
      input logic [63:0] desc, input int delay, input string req);
      @(negedge clk);
      load_valid = 1'b1; load_seg = seg; load_sel = sel;
      @(negedge clk);
      load_valid = 1'b0;
      chk(mem_req == exp_req, req, mem_req, exp_req);
      if (exp_req) begin
         chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
         chk(load_ready == 1'b0, "R10", load_ready, 0);
         repeat (delay) @(negedge clk);
         mem_valid = 1'b1; mem_data = desc;
         @(negedge clk);
         mem_valid = 1'b0;
         chk(mem_req == 1'b0, req, mem_req, 0);
      end
   endtask

   task automatic xlate(input logic [1:0] seg, input logic [31:0] off,
      input bit exp_stall, input logic [31:0] exp_lin, input bit exp_fault,
      input string req);
      @(negedge clk);
      xl_valid = 1'b1; xl_seg = seg; xl_off = off;
      #1;
      chk(xl_stall == exp_stall, {req, " stall"}, xl_stall, exp_stall);
      @(negedge clk);
      xl_valid = 1'b0;
      chk(xl_ack == !exp_stall, {req, " ack"}, xl_ack, !exp_stall);
      if (!exp_stall) begin
         chk(xl_fault == exp_fault, {req, " fault"}, xl_fault, exp_fault);
         chk(xl_lin == exp_lin, {req, " lin"}, xl_lin, exp_lin);
      end
   endtask

   task automatic t_reset;
      chk(load_ready == 1'b1, "R1 ready", load_ready, 1);
      chk(mem_req == 1'b0, "R1 req", mem_req, 0);
      chk(xl_ack == 1'b0, "R1 ack", xl_ack, 0);
      xlate(2'd0, 32'h0, 1'b0, 32'h0, 1'b1, "R1 null code");
      xlate(2'd2, 32'h10, 1'b0, 32'h0, 1'b1, "R1 null stack");
   endtask

   task automatic t_byte_limit;
      // code: GDT index 2 -> 0x10000 + 16
      do_load(2'd0, 16'h0010, 1'b1, 32'h0001_0010,
              mk_desc(32'h1234_5678, 20'h00FFF, 1'b0, 4'hA, 1'b1, 2'd0), 1, "R2 gdt");
      xlate(2'd0, 32'h100, 1'b0, 32'h1234_5778, 1'b0, "R4 sum");
      chk(xl_type == 4'hA && xl_sys == 1'b1 && xl_dpl == 2'd0 && xl_rpl == 2'd0,
          "R9 code attrs", {xl_type, xl_sys, xl_dpl, xl_rpl}, {4'hA, 1'b1, 2'd0, 2'd0});
      xlate(2'd0, 32'hFFF, 1'b0, 32'h1234_6677, 1'b0, "R5 at limit");
      xlate(2'd0, 32'h1000, 1'b0, 32'h0, 1'b1, "R5 over limit");
   endtask

   task automatic t_page_limit;
      // data: LDT index 5, rpl 3 -> 0x800000 + 40
      do_load(2'd1, 16'h002F, 1'b1, 32'h0080_0028,
              mk_desc(32'h0040_0000, 20'h00003, 1'b1, 4'h2, 1'b1, 2'd3), 0, "R2 ldt");
      xlate(2'd1, 32'h3FFF, 1'b0, 32'h0040_3FFF, 1'b0, "R6 at page limit");
      chk(xl_type == 4'h2 && xl_dpl == 2'd3 && xl_rpl == 2'd3,
          "R9 data attrs", {xl_type, xl_dpl, xl_rpl}, {4'h2, 2'd3, 2'd3});
      xlate(2'd1, 32'h4000, 1'b0, 32'h0, 1'b1, "R6 over page limit");
   endtask

   task automatic t_null_sel;
      do_load(2'd2, 16'h0003, 1'b0, 32'h0, 64'h0, 0, "R3 null no req");
      chk(load_ready == 1'b1, "R3 ready", load_ready, 1);
      xlate(2'd2, 32'h0, 1'b0, 32'h0, 1'b1, "R3 null faults");
      // index 0 in the local table is not null
      do_load(2'd2, 16'h0004, 1'b1, 32'h0080_0000,
              mk_desc(32'hFFFF_F000, 20'hFFFFF, 1'b1, 4'h2, 1'b1, 2'd0), 2, "R3 ldt idx0");
      xlate(2'd2, 32'h2000, 1'b0, 32'h0000_1000, 1'b0, "R4 wrap");
   endtask

   task automatic t_stall;
      @(negedge clk);
      load_valid = 1'b1; load_seg = 2'd1; load_sel = 16'h0018;
      @(negedge clk);
      load_valid = 1'b0;
      chk(mem_req == 1'b1 && mem_addr == 32'h0001_0018, "R2 reload",
          mem_addr, 32'h0001_0018);
      chk(load_ready == 1'b0, "R10 ready low", load_ready, 0);
      // a load during the fetch must be ignored
      @(negedge clk);
      load_valid = 1'b1; load_seg = 2'd0; load_sel = 16'h0000;
      @(negedge clk);
      load_valid = 1'b0;
      xlate(2'd1, 32'h10, 1'b1, 32'h0, 1'b0, "R7 stalled");
      xlate(2'd0, 32'h100, 1'b0, 32'h1234_5778, 1'b0, "R7 R10 other reg");
      @(negedge clk);
      mem_valid = 1'b1; mem_data = mk_desc(32'h0000_5000, 20'h00010, 1'b0, 4'h2, 1'b1, 2'd0);
      @(negedge clk);
      mem_valid = 1'b0;
      xlate(2'd1, 32'h10, 1'b0, 32'h0000_5010, 1'b0, "R7 after fill");
      xlate(2'd1, 32'h11, 1'b0, 32'h0, 1'b1, "R7 new limit");
   endtask

   task automatic t_cached;
      @(negedge clk);
      gdt_base = 32'h0999_0000; ldt_base = 32'h0;
      mem_data = '1;
      xlate(2'd0, 32'h100, 1'b0, 32'h1234_5778, 1'b0, "R8 cache kept");
      chk(mem_req == 1'b0, "R8 no req", mem_req, 0);
      chk(xl_type == 4'hA, "R8 attrs kept", xl_type, 4'hA);
   endtask

   task automatic t_range;
      xlate(2'd3, 32'h0, 1'b0, 32'h0, 1'b1, "R11 bad register");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_byte_limit;
      t_page_limit;
      t_null_sel;
      t_stall;
      t_cached;
      t_range;
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule